// File: doc/BRIEF.md
# Indexed Performance Counter Bank

The block holds a small bank of event counters behind a single-cycle register port. Software first writes a counter number into a selector register; the configuration, count, limit and capture registers then act only on that counter. Each counter follows one condition line, chosen by a condition number, and can be limited to kernel-mode or user-mode activity. A global run bit starts or halts every counter together. Condition number zero never counts, and writing it is the only per-counter stop.

A capture command copies the selected counter into a holding register pair, so software reads a stable value in two 32-bit halves while counting goes on. Each counter has a limit; the cycle an increment lands on the limit raises that counter's pending flag, provided its enable bit is set. Pending flags are sticky, OR together onto `irq`, and are cleared by writing one. That write also drops the matching enable. Read-only registers report the bank's shape and an eight-character name for each condition.

Top module: `pctr_bank`

Register map (word addresses): 0 SHAPE (RO), 1 CONDS (RO), 2 CTRL, 3 SEL, 4 CFG, 5 CNT_LO, 6 CNT_HI, 7 CAP_LO (RO), 8 CAP_HI (RO), 9 LIM_LO, 10 LIM_HI, 11 IEN, 12 IPEND, 13 CSEL, 14 NAME_LO (RO), 15 NAME_HI (RO).

## Requirements
- R1: After reset every counter, limit and configuration is zero, CTRL reads 0, IPEND and IEN read 0 and `irq` is low.
- R2: SEL picks the counter that CFG, CNT_LO/HI, LIM_LO/HI and the capture command act on; other counters are untouched. With SEL at or above the counter count, those writes are ignored and those reads return 0.
- R3: A counter adds one on each clock edge where the run bit is set, its CFG[14:0] condition number is nonzero and below the condition count, and that line of `cond_in` is high. Condition 0 never counts.
- R4: CFG bit 16 restricts counting to kernel mode (`user_mode` low); CFG bit 17 restricts it to user mode (`user_mode` high).
- R5: CTRL bit 0 is the global run bit; while it is 0 no counter changes. CTRL bits 31:16 are stored and read back unchanged.
- R6: Writing CNT_LO loads count bits 31:0 and CNT_HI loads bits 47:32 of the selected counter; a load in the same cycle as an increment wins and the increment is lost.
- R7: Writing CTRL with bit 1 set copies the selected counter as it stood before that edge into CAP_LO/CAP_HI; the capture then holds while counting continues. CTRL bit 1 reads 0.
- R8: An increment whose result equals the counter's limit sets its IPEND bit only if its IEN bit is set; IPEND bits stay set until cleared, and `irq` is high while any IPEND bit is set.
- R9: Writing IPEND clears every IPEND bit written as 1 and also clears the same IEN bits.
- R10: SHAPE reads present flag in bit 0, counter count in bits 13:8, interrupt support in bit 16 and size code s in bits 21:20 (width 32+16*s); defaults give 0x00110401. CONDS reads the condition count (16).
- R11: With CSEL below the condition count, NAME_LO/NAME_HI return the name "EVT_" followed by two upper-case hex digits of the condition and two spaces, first character in the lowest byte of NAME_LO; otherwise both read 0.
- R12: Addresses 16 and above read 0.
- R13: A counter at all ones wraps to zero on its next increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| we | input | 1 | Write strobe |
| addr | input | 5 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr |
| cond_in | input | 16 | Countable condition lines |
| user_mode | input | 1 | 1 in user mode, 0 in kernel mode |
| irq | output | 1 | OR of pending flags |

## Verification
On every cycle the checker confirms that a pending flag only appears where its enable was set, that a clearing write leaves none of the written enables standing, that `irq` only falls after a clearing write, that the bank is frozen while stopped and idle, and that the capture pair moves only on a capture command. Exact counts, the load-over-increment priority, mode filtering, index isolation, wrap, the shape and name registers and the capture value itself depend on chosen stimulus sequences and are shown only by the bench's scenarios.

// File: rtl/pctr_bank.sv
module pctr_bank #(
  parameter int NUM_CTR  = 4,
  parameter int SIZE_SEL = 1,
  parameter int NUM_COND = 16,
  parameter int ADDR_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic [NUM_COND-1:0] cond_in,
  input  logic              user_mode,
  output logic              irq
);
  localparam int CW  = 32 + 16 * SIZE_SEL;
  localparam int HW  = CW - 32;
  localparam int SIW = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1;
  localparam int CIW = (NUM_COND > 1) ? $clog2(NUM_COND) : 1;

  localparam logic [ADDR_W-1:0] A_SHAPE = 0, A_CONDS = 1, A_CTRL = 2, A_SEL = 3,
    A_CFG = 4, A_CNTL = 5, A_CNTH = 6, A_CAPL = 7, A_CAPH = 8, A_LIML = 9,
    A_LIMH = 10, A_IEN = 11, A_IPEND = 12, A_CSEL = 13, A_NAML = 14, A_NAMH = 15;

  logic                         run;
  logic [15:0]                  ctrl_hi;
  logic [4:0]                   sel;
  logic [7:0]                   csel;
  logic [NUM_CTR-1:0][CW-1:0]   cnt;
  logic [NUM_CTR-1:0][CW-1:0]   lim;
  logic [NUM_CTR-1:0][17:0]     cfg;
  logic [CW-1:0]                snap;
  logic [NUM_CTR-1:0]           ien, iact, hit;

  wire              sel_ok  = int'(sel) < NUM_CTR;
  wire              csel_ok = int'(csel) < NUM_COND;
  wire [SIW-1:0]    sidx    = sel[SIW-1:0];
  wire [CW-1:0]     cur_cnt = sel_ok ? cnt[sidx] : '0;
  wire [CW-1:0]     cur_lim = sel_ok ? lim[sidx] : '0;
  wire [17:0]       cur_cfg = sel_ok ? cfg[sidx] : '0;

  function automatic logic [7:0] hexc(input logic [3:0] d);
    return (d < 4'd10) ? 8'h30 + {4'h0, d} : 8'h37 + {4'h0, d};
  endfunction

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
    wire [14:0] cn    = cfg[g][14:0];
    wire        c_ok  = (cn != 15'd0) && (int'(cn) < NUM_COND) && cond_in[cn[CIW-1:0]];
    wire        m_ok  = !(cfg[g][16] && user_mode) && !(cfg[g][17] && !user_mode);
    wire        inc   = run && c_ok && m_ok;
    wire        mine  = we && sel_ok && (int'(sel) == g);
    wire        ld_lo = mine && (addr == A_CNTL);
    wire        ld_hi = mine && (addr == A_CNTH);
    wire [CW-1:0] nxt = cnt[g] + 1'b1;

    assign hit[g] = inc && !ld_lo && !ld_hi && (nxt == lim[g]) && ien[g];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt[g] <= '0;
        lim[g] <= '0;
        cfg[g] <= '0;
      end else begin
        if (ld_lo)      cnt[g][31:0]   <= wdata;
        else if (ld_hi) cnt[g][CW-1:32] <= wdata[HW-1:0];
        else if (inc)   cnt[g]         <= nxt;
        if (mine && addr == A_LIML) lim[g][31:0]    <= wdata;
        if (mine && addr == A_LIMH) lim[g][CW-1:32] <= wdata[HW-1:0];
        if (mine && addr == A_CFG)  cfg[g] <= {wdata[17:16], 1'b0, wdata[14:0]};
      end
    end
  end

  wire [NUM_CTR-1:0] clr = (we && addr == A_IPEND) ? wdata[NUM_CTR-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run     <= 1'b0;
      ctrl_hi <= '0;
      sel     <= '0;
      csel    <= '0;
      snap    <= '0;
      ien     <= '0;
      iact    <= '0;
    end else begin
      if (we && addr == A_CTRL) begin
        run     <= wdata[0];
        ctrl_hi <= wdata[31:16];
        if (wdata[1] && sel_ok) snap <= cur_cnt;
      end
      if (we && addr == A_SEL)  sel  <= wdata[4:0];
      if (we && addr == A_CSEL) csel <= wdata[7:0];
      if (we && addr == A_IEN)  ien  <= wdata[NUM_CTR-1:0];
      else                      ien  <= ien & ~clr;
      iact <= (iact & ~clr) | hit;
    end
  end

  assign irq = |iact;

  always_comb begin
    rdata = '0;
    case (addr)
      A_SHAPE: rdata = {10'd0, 2'(SIZE_SEL), 3'd0, 1'b1, 2'd0, 6'(NUM_CTR), 7'd0, 1'b1};
      A_CONDS: rdata = 32'(NUM_COND);
      A_CTRL:  rdata = {ctrl_hi, 15'd0, run};
      A_SEL:   rdata = {27'd0, sel};
      A_CFG:   rdata = {14'd0, cur_cfg};
      A_CNTL:  rdata = cur_cnt[31:0];
      A_CNTH:  rdata = 32'(cur_cnt[CW-1:32]);
      A_CAPL:  rdata = snap[31:0];
      A_CAPH:  rdata = 32'(snap[CW-1:32]);
      A_LIML:  rdata = cur_lim[31:0];
      A_LIMH:  rdata = 32'(cur_lim[CW-1:32]);
      A_IEN:   rdata = 32'(ien);
      A_IPEND: rdata = 32'(iact);
      A_CSEL:  rdata = {24'd0, csel};
      A_NAML:  rdata = csel_ok ? {8'h5F, 8'h54, 8'h56, 8'h45} : '0;
      A_NAMH:  rdata = csel_ok ? {8'h20, 8'h20, hexc(csel[3:0]), hexc(csel[7:4])} : '0;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/pctr_bank_chk.sv
module pctr_bank_chk #(
  parameter int N  = 4,
  parameter int W  = 48,
  parameter int AW = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                we,
  input logic [AW-1:0]       addr,
  input logic [31:0]         wdata,
  input logic                run,
  input logic [N-1:0]        ien,
  input logic [N-1:0]        iact,
  input logic                irq,
  input logic [W-1:0]        snap,
  input logic [N-1:0][W-1:0] cnt
);
  localparam logic [AW-1:0] A_CTRL = 2, A_IPEND = 12;

  assert_pend_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((iact & ~$past(iact) & ~$past(ien)) == '0));

  assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(we && addr == A_IPEND));

  assert_clear_drops_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == A_IPEND) |=> ((ien & $past(wdata[N-1:0])) == '0));

  assert_stopped_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !we) |=> $stable(cnt));

  assert_capture_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && addr == A_CTRL && wdata[1]) |=> $stable(snap));
endmodule

bind pctr_bank pctr_bank_chk #(.N(NUM_CTR), .W(CW), .AW(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata), .run(run),
  .ien(ien), .iact(iact), .irq(irq), .snap(snap), .cnt(cnt));

// File: tb/pctr_bank_bench.sv
module pctr_bank_bench;
  logic        clk = 0, rst_n = 0, we = 0, user_mode = 0;
  logic [4:0]  addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [15:0] cond_in = 0;
  logic        irq;
  int checks = 0, fails = 0;
  logic [31:0] v;

  localparam int SHAPE = 0, CONDS = 1, CTRL = 2, SEL = 3, CFG = 4, CNTL = 5, CNTH = 6,
    CAPL = 7, CAPH = 8, LIML = 9, LIMH = 10, IEN = 11, IPEND = 12, CSEL = 13, NAML = 14, NAMH = 15;

  pctr_bank u_pctr_bank (.clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .cond_in(cond_in), .user_mode(user_mode), .irq(irq));

  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); addr = 5'(a); wdata = d; we = 1;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk); addr = 5'(a); #1 d = rdata;
  endtask

  task automatic setup(input int idx, input logic [31:0] cfgv, input logic [31:0] lo);
    wr(SEL, idx); wr(CFG, cfgv); wr(CNTH, 0); wr(CNTL, lo);
  endtask

  task automatic pulse(input int line, input int n);
    @(negedge clk); cond_in[line] = 1;
    repeat (n) @(negedge clk);
    cond_in[line] = 0;
  endtask

  task automatic t_reset;
    rd(CTRL, v);  chk("R1 ctrl", v, 0);
    rd(IPEND, v); chk("R1 ipend", v, 0);
    rd(IEN, v);   chk("R1 ien", v, 0);
    rd(CNTL, v);  chk("R1 count", v, 0);
    chk("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_shape;
    rd(SHAPE, v); chk("R10 shape", v, 32'h0011_0401);
    rd(CONDS, v); chk("R10 conds", v, 16);
  endtask

  task automatic t_names;
    wr(CSEL, 10);
    rd(NAML, v); chk("R11 name lo", v, 32'h5F54_5645);
    rd(NAMH, v); chk("R11 name hi", v, 32'h2020_4130);
    wr(CSEL, 16);
    rd(NAMH, v); chk("R11 out of range", v, 0);
  endtask

  task automatic t_unimpl;
    rd(20, v); chk("R12 addr 20", v, 0);
    rd(31, v); chk("R12 addr 31", v, 0);
  endtask

  task automatic t_count;
    setup(0, 3, 0); wr(CTRL, 1);
    pulse(3, 7);
    rd(CNTL, v); chk("R3 seven events", v, 7);
    wr(CFG, 0); cond_in = 16'hFFFF;
    repeat (5) @(negedge clk);
    cond_in = 0;
    rd(CNTL, v); chk("R3 condition zero", v, 7);
  endtask

  task automatic t_mode;
    setup(0, 32'h0001_0005, 0);
    user_mode = 1; pulse(5, 4);
    rd(CNTL, v); chk("R4 kernel-only in user", v, 0);
    user_mode = 0; pulse(5, 4);
    rd(CNTL, v); chk("R4 kernel-only in kernel", v, 4);
    wr(CFG, 32'h0002_0005);
    pulse(5, 3);
    rd(CNTL, v); chk("R4 user-only in kernel", v, 4);
    user_mode = 1; pulse(5, 3);
    rd(CNTL, v); chk("R4 user-only in user", v, 7);
    user_mode = 0;
  endtask

  task automatic t_run;
    setup(0, 3, 0);
    wr(CTRL, 32'hABCD_0000);
    pulse(3, 6);
    rd(CNTL, v); chk("R5 stopped", v, 0);
    rd(CTRL, v); chk("R5 upper bits", v, 32'hABCD_0000);
    wr(CTRL, 32'hABCD_0001);
    rd(CTRL, v); chk("R5 run readback", v, 32'hABCD_0001);
  endtask

  task automatic t_load;
    setup(0, 3, 0);
    @(negedge clk); cond_in[3] = 1;
    repeat (3) @(negedge clk);
    addr = CNTL; wdata = 100; we = 1;
    @(negedge clk); we = 0; cond_in[3] = 0;
    rd(CNTL, v); chk("R6 load beats increment", v, 100);
    wr(CNTH, 32'h0000_1234);
    rd(CNTH, v); chk("R6 high half", v, 32'h1234);
    rd(CNTL, v); chk("R6 low kept", v, 100);
  endtask

  task automatic t_snap;
    setup(0, 3, 0);
    @(negedge clk); cond_in[3] = 1;
    repeat (5) @(negedge clk);
    addr = CTRL; wdata = 3; we = 1;
    @(negedge clk); we = 0;
    repeat (4) @(negedge clk);
    cond_in[3] = 0;
    rd(CAPL, v); chk("R7 capture value", v, 5);
    rd(CAPH, v); chk("R7 capture high", v, 0);
    rd(CNTL, v); chk("R7 count ran on", v, 10);
    rd(CTRL, v); chk("R7 command bit reads 0", v, 1);
  endtask

  task automatic t_index;
    setup(1, 4, 50);
    setup(0, 3, 0);
    pulse(4, 5);
    wr(SEL, 1); rd(CNTL, v); chk("R2 counter 1 counted", v, 55);
    wr(SEL, 0); rd(CNTL, v); chk("R2 counter 0 idle", v, 0);
    wr(SEL, 4); wr(CNTL, 77);
    rd(CNTL, v); chk("R2 out-of-range read", v, 0);
    wr(SEL, 0); rd(CNTL, v); chk("R2 out-of-range write ignored", v, 0);
    wr(SEL, 1); rd(CNTL, v); chk("R2 counter 1 untouched", v, 55);
  endtask

  task automatic t_irq;
    setup(0, 3, 7); wr(LIML, 10); wr(LIMH, 0);
    setup(1, 3, 7); wr(LIML, 10); wr(LIMH, 0);
    wr(IEN, 1);
    pulse(3, 3);
    rd(IPEND, v); chk("R8 only enabled pends", v, 1);
    chk("R8 irq high", 32'(irq), 1);
    pulse(3, 4);
    chk("R8 irq sticky", 32'(irq), 1);
    wr(IPEND, 1);
    rd(IPEND, v); chk("R9 cleared", v, 0);
    rd(IEN, v);   chk("R9 enable dropped", v, 0);
    chk("R9 irq low", 32'(irq), 0);
  endtask

  task automatic t_wrap;
    setup(2, 3, 32'hFFFF_FFFF); wr(CNTH, 32'hFFFF);
    pulse(3, 1);
    rd(CNTL, v); chk("R13 wrap low", v, 0);
    rd(CNTH, v); chk("R13 wrap high", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset; t_shape; t_names; t_unimpl; t_count; t_mode; t_run;
    t_load; t_snap; t_index; t_irq; t_wrap;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule